// File: doc/BRIEF.md
# Half-Rate Command Slot Shifter

This block sits in the address and command path between a memory controller and a DDR/DDR2 physical layer. The controller clock runs at half the memory clock, so each controller cycle carries two memory-clock command slots, each with an address, a bank and four active-low control bits. The block can delay the whole command stream by one memory clock. It does this by holding the second slot of a cycle and sending it as the first slot of the next cycle. This lets command timing line up with write data when the write latency is an odd number of memory clocks.

A mode parameter fixes the one-slot delay on, fixes it off, or hands control to a run-time select pin. Switching at run time is safe. When the delay is enabled, a NOP fills the gap. When it is disabled, the held slot is drained during a one-cycle stall of the input. A second mode parameter, with its own select pin, adds an optional full-cycle register stage. In the run-time case that stage is switched in or out only while it holds an idle pair.

The input is a valid/ready stream. A pair is taken on a rising edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, the controller must hold the same pair. `in_ready` is a function of the current delay state and `shift_sel` only. It never depends on `in_valid`. The output side has no back-pressure: the physical layer consumes both slots every cycle, and idle slots carry NOPs.

Top module: `hr_cmd_shifter`

## Requirements
- R1: While reset is asserted, every output slot is a NOP and `in_ready` is 1. A NOP slot has control bits `{cs_n,ras_n,cas_n,we_n}` = 4'b1111, with bank 0 and address 0.
- R2: With the delay inactive and the extra stage out, the pair taken at edge t appears after edge t in the same slot order. This is a latency of 2 memory-clock slots.
- R3: With the delay active, output slot 0 carries the previous cycle's input slot 1, and output slot 1 carries the current cycle's input slot 0. This is a latency of 3 slots.
- R4: In the fixed-on and fixed-off modes, the select pins are ignored and `in_ready` stays 1. Fixed-on gives a latency of 3 slots. The fixed extra stage adds 2 slots.
- R5: In the first cycle after the delay is enabled at run time, output slot 0 is a NOP.
- R6: When the delay is disabled at run time, `in_ready` is 0 for exactly one cycle. In that cycle the held slot is sent as output slot 0, and output slot 1 is a NOP.
- R7: A slot that is not taken from the input (in_valid low or stalled) becomes a NOP. Every output slot with cs_n high is a full NOP.
- R8: The extra register stage delays both slots together by one controller cycle (2 slots), and slot pairing is unchanged.
- R9: In run-time mode, the extra-stage select takes effect only on an edge where the shifter output pair is all NOPs. Toggling it under continuous traffic has no effect.
- R10: In every mode and across any sequence of select changes, commands leave in the order they entered. No command is lost or duplicated, and each keeps its bank and control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller (half-rate) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_sel | input | 1 | Run-time one-slot delay request (run-time mode only) |
| ireg_sel | input | 1 | Run-time extra-stage request (run-time mode only) |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Input pair accepted when high with in_valid |
| in_addr | input | 2*ADDR_W | Slot addresses, slot 0 in the low half |
| in_bank | input | 2*BANK_W | Slot banks, slot 0 in the low half |
| in_ctl | input | 8 | Slot control {cs_n,ras_n,cas_n,we_n}, slot 0 in bits 3:0 |
| out_addr | output | 2*ADDR_W | Output slot addresses |
| out_bank | output | 2*BANK_W | Output slot banks |
| out_ctl | output | 8 | Output slot control bits |

## Verification
A held-slot register with the wrong content shows at the ports one cycle later. It appears as a wrong, repeated or missing command in output slot 0, which the sequence numbers carried in the address field expose. A delay-state flop out of step with the select shows at once as a wrong `in_ready` value. Within one command it also shows as an output position off by one slot. A wrong extra-stage selection shifts every later command by two slots, and a switch at a non-idle edge shows as a duplicated or skipped number.

// File: rtl/hr_cmd_pkg.sv
package hr_cmd_pkg;
  // How a latency feature is controlled
  typedef enum logic [1:0] {
    LAT_OFF = 2'd0,
    LAT_ON  = 2'd1,
    LAT_EXT = 2'd2
  } lat_mode_e;

  // Control bits per slot: {cs_n, ras_n, cas_n, we_n}
  localparam int CTL_W = 4;
  // Half rate: two memory-clock slots per controller cycle
  localparam int SLOTS = 2;
endpackage

// File: rtl/hr_cmd_mode_sel.sv
module hr_cmd_mode_sel
  import hr_cmd_pkg::*;
#(
  parameter lat_mode_e MODE = LAT_EXT
) (
  input  logic sel,
  output logic en
);
  generate
    if (MODE == LAT_ON) begin : g_on
      logic unused_sel;
      assign unused_sel = sel;
      assign en = 1'b1;
    end else if (MODE == LAT_OFF) begin : g_off
      logic unused_sel;
      assign unused_sel = sel;
      assign en = 1'b0;
    end else begin : g_ext
      assign en = sel;
    end
  endgenerate
endmodule

// File: rtl/hr_cmd_slot_shift.sv
module hr_cmd_slot_shift
  import hr_cmd_pkg::*;
#(
  parameter int SLOT_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              want,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SLOT_W-1:0] in0,
  input  logic [SLOT_W-1:0] in1,
  output logic [SLOT_W-1:0] out0,
  output logic [SLOT_W-1:0] out1
);
  localparam logic [SLOT_W-1:0] NOP = {{CTL_W{1'b1}}, {(SLOT_W-CTL_W){1'b0}}};

  logic              dly_q;
  logic [SLOT_W-1:0] held_q;
  logic [SLOT_W-1:0] src0, src1;
  logic [SLOT_W-1:0] nxt0, nxt1, nxt_held;
  logic              take;

  // Stall only in the one cycle that drains the held slot
  assign in_ready = !(dly_q && !want);
  assign take     = in_valid && in_ready;
  assign src0     = take ? in0 : NOP;
  assign src1     = take ? in1 : NOP;

  always_comb begin
    if (want) begin
      // held_q is a NOP on the enabling cycle, so slot 0 idles there
      nxt0     = held_q;
      nxt1     = src0;
      nxt_held = src1;
    end else if (dly_q) begin
      // disabling: emit the held slot, nothing new enters
      nxt0     = held_q;
      nxt1     = NOP;
      nxt_held = NOP;
    end else begin
      nxt0     = src0;
      nxt1     = src1;
      nxt_held = NOP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q  <= 1'b0;
      held_q <= NOP;
      out0   <= NOP;
      out1   <= NOP;
    end else begin
      dly_q  <= want;
      held_q <= nxt_held;
      out0   <= nxt0;
      out1   <= nxt1;
    end
  end
endmodule

// File: rtl/hr_cmd_pipe_stage.sv
module hr_cmd_pipe_stage
  import hr_cmd_pkg::*;
#(
  parameter lat_mode_e MODE   = LAT_EXT,
  parameter int        SLOT_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              want,
  input  logic [SLOT_W-1:0] a0,
  input  logic [SLOT_W-1:0] a1,
  output logic [SLOT_W-1:0] y0,
  output logic [SLOT_W-1:0] y1
);
  localparam logic [SLOT_W-1:0] NOP = {{CTL_W{1'b1}}, {(SLOT_W-CTL_W){1'b0}}};

  generate
    if (MODE == LAT_OFF) begin : g_bypass
      logic unused_p;
      assign unused_p = clk ^ rst_n ^ want;
      assign y0 = a0;
      assign y1 = a1;
    end else begin : g_reg
      logic [SLOT_W-1:0] b0_q, b1_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          b0_q <= NOP;
          b1_q <= NOP;
        end else begin
          b0_q <= a0;
          b1_q <= a1;
        end
      end

      if (MODE == LAT_ON) begin : g_fixed
        logic unused_w;
        assign unused_w = want;
        assign y0 = b0_q;
        assign y1 = b1_q;
      end else begin : g_sel
        logic use_q;
        logic a_idle;
        // switching on an idle pair can neither repeat nor skip a command
        assign a_idle = (a0 == NOP) && (a1 == NOP);
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)      use_q <= 1'b0;
          else if (a_idle) use_q <= want;
        end
        assign y0 = use_q ? b0_q : a0;
        assign y1 = use_q ? b1_q : a1;
      end
    end
  endgenerate
endmodule

// File: rtl/hr_cmd_shifter.sv
module hr_cmd_shifter
  import hr_cmd_pkg::*;
#(
  parameter int        ADDR_W     = 14,
  parameter int        BANK_W     = 3,
  parameter lat_mode_e SHIFT_MODE = LAT_EXT,
  parameter lat_mode_e IREG_MODE  = LAT_EXT
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift_sel,
  input  logic                      ireg_sel,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [SLOTS*ADDR_W-1:0]   in_addr,
  input  logic [SLOTS*BANK_W-1:0]   in_bank,
  input  logic [SLOTS*CTL_W-1:0]    in_ctl,
  output logic [SLOTS*ADDR_W-1:0]   out_addr,
  output logic [SLOTS*BANK_W-1:0]   out_bank,
  output logic [SLOTS*CTL_W-1:0]    out_ctl
);
  localparam int SLOT_W = CTL_W + BANK_W + ADDR_W;

  logic              shift_want, ireg_want;
  logic [SLOT_W-1:0] in_sl [SLOTS];
  logic [SLOT_W-1:0] pp_sl [SLOTS];
  logic [SLOT_W-1:0] sh0, sh1;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign in_sl[i] = {in_ctl[i*CTL_W +: CTL_W], in_bank[i*BANK_W +: BANK_W],
                       in_addr[i*ADDR_W +: ADDR_W]};
    assign out_ctl[i*CTL_W +: CTL_W]    = pp_sl[i][SLOT_W-1 -: CTL_W];
    assign out_bank[i*BANK_W +: BANK_W] = pp_sl[i][ADDR_W +: BANK_W];
    assign out_addr[i*ADDR_W +: ADDR_W] = pp_sl[i][ADDR_W-1:0];
  end

  hr_cmd_mode_sel #(.MODE(SHIFT_MODE)) u_shift_mode (.sel(shift_sel), .en(shift_want));
  hr_cmd_mode_sel #(.MODE(IREG_MODE))  u_ireg_mode  (.sel(ireg_sel),  .en(ireg_want));

  hr_cmd_slot_shift #(.SLOT_W(SLOT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .want     (shift_want),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in0      (in_sl[0]),
    .in1      (in_sl[1]),
    .out0     (sh0),
    .out1     (sh1)
  );

  hr_cmd_pipe_stage #(.MODE(IREG_MODE), .SLOT_W(SLOT_W)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .want  (ireg_want),
    .a0    (sh0),
    .a1    (sh1),
    .y0    (pp_sl[0]),
    .y1    (pp_sl[1])
  );
endmodule

// File: rtl/hr_cmd_shifter_chk.sv
module hr_cmd_shifter_chk
  import hr_cmd_pkg::*;
#(
  parameter int        SLOT_W     = 21,
  parameter lat_mode_e SHIFT_MODE = LAT_EXT,
  parameter lat_mode_e IREG_MODE  = LAT_EXT
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   shift_want,
  input logic                   in_ready,
  input logic [SLOTS*CTL_W-1:0] out_ctl,
  input logic [SLOT_W-1:0]      sh0,
  input logic [SLOT_W-1:0]      sh1
);
  // R1: outputs still hold the NOP reset value at the first edge after release
  a_r1_reset_nop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_ctl == {(SLOTS*CTL_W){1'b1}}));

  // R6: a stall lasts a single cycle
  a_r6_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  // R6: the drain cycle leaves shifter slot 1 idle
  a_r6_drain_nop: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (sh1[SLOT_W-1 -: CTL_W] == {CTL_W{1'b1}}));

  // R5: enabling the delay idles shifter slot 0 once
  a_r5_enable_nop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_want) |=> sh0[SLOT_W-1]);

  generate
    if (SHIFT_MODE != LAT_EXT) begin : g_fixed_shift
      // R4: fixed modes never stall
      a_r4_fixed_ready: assert property (@(posedge clk) disable iff (!rst_n) in_ready);
    end
    if (IREG_MODE == LAT_ON) begin : g_fixed_ireg
      // R8: fixed extra stage shows the shifter pair one cycle later
      a_r8_ireg_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        out_ctl == {$past(sh1[SLOT_W-1 -: CTL_W]), $past(sh0[SLOT_W-1 -: CTL_W])});
    end
  endgenerate
endmodule

bind hr_cmd_shifter hr_cmd_shifter_chk #(
  .SLOT_W(SLOT_W), .SHIFT_MODE(SHIFT_MODE), .IREG_MODE(IREG_MODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_want(shift_want), .in_ready(in_ready),
  .out_ctl(out_ctl), .sh0(sh0), .sh1(sh1)
);

// File: tb/test_hr_cmd_shifter.sv
`timescale 1ns/1ps
module test_hr_cmd_shifter;
  import hr_cmd_pkg::*;

  localparam int AW   = 14;
  localparam int BW   = 3;
  localparam int NCMD = 4096;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n, shift_sel, ireg_sel, in_valid, acc_valid;
  logic [2*AW-1:0] in_addr;
  logic [2*BW-1:0] in_bank;
  logic [7:0]      in_ctl;
  logic            rdy   [3];
  logic [2*AW-1:0] oaddr [3];
  logic [2*BW-1:0] obank [3];
  logic [7:0]      octl  [3];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  checks = 0, errors = 0;
  int  n_in = 0;
  int  nout [3];
  int  pos_in [NCMD];
  int  exp0 [NCMD];
  bit  m_dly = 1'b0, m_reg = 1'b0, cur_ssel = 1'b0, cur_rsel = 1'b0;
  bit  done = 1'b0;

  assign acc_valid = in_valid & rdy[0];

  hr_cmd_shifter #(.ADDR_W(AW), .BANK_W(BW), .SHIFT_MODE(LAT_EXT), .IREG_MODE(LAT_EXT)) i_hr_cmd_shifter (
    .clk(clk), .rst_n(rst_n), .shift_sel(shift_sel), .ireg_sel(ireg_sel),
    .in_valid(in_valid), .in_ready(rdy[0]), .in_addr(in_addr), .in_bank(in_bank), .in_ctl(in_ctl),
    .out_addr(oaddr[0]), .out_bank(obank[0]), .out_ctl(octl[0]));

  hr_cmd_shifter #(.ADDR_W(AW), .BANK_W(BW), .SHIFT_MODE(LAT_ON), .IREG_MODE(LAT_OFF)) i_hr_cmd_shifter_on (
    .clk(clk), .rst_n(rst_n), .shift_sel(~shift_sel), .ireg_sel(1'b1),
    .in_valid(acc_valid), .in_ready(rdy[1]), .in_addr(in_addr), .in_bank(in_bank), .in_ctl(in_ctl),
    .out_addr(oaddr[1]), .out_bank(obank[1]), .out_ctl(octl[1]));

  hr_cmd_shifter #(.ADDR_W(AW), .BANK_W(BW), .SHIFT_MODE(LAT_OFF), .IREG_MODE(LAT_ON)) i_hr_cmd_shifter_reg (
    .clk(clk), .rst_n(rst_n), .shift_sel(1'b1), .ireg_sel(1'b0),
    .in_valid(acc_valid), .in_ready(rdy[2]), .in_addr(in_addr), .in_bank(in_bank), .in_ctl(in_ctl),
    .out_addr(oaddr[2]), .out_bank(obank[2]), .out_ctl(octl[2]));

  function automatic logic [3:0] mk_ctl(int n);
    return {1'b0, n[0], ~n[0], n[1]};
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  task automatic observe();
    for (int k = 0; k < 3; k++) begin
      for (int s = 0; s < 2; s++) begin
        logic [3:0]    c;
        logic [AW-1:0] a;
        logic [BW-1:0] b;
        int seq, pos, ep;
        c = octl[k][s*4 +: 4];
        a = oaddr[k][s*AW +: AW];
        b = obank[k][s*BW +: BW];
        if (c[3]) begin
          chk(c == 4'hF && a == '0 && b == '0, "R7 idle slot is full NOP", int'(c), 15);
        end else begin
          seq = int'(a);
          pos = 2*cyc + s;
          chk(seq == nout[k], "R10 order/no loss", seq, nout[k]);
          if (seq < n_in) begin
            ep = (k == 0) ? exp0[seq] : pos_in[seq] + ((k == 1) ? 1 : 2);
            if (k == 0)      chk(pos == ep, "R2/R3/R8 latency slot", pos, ep);
            else if (k == 1) chk(pos == ep, "R4 fixed-on latency slot", pos, ep);
            else             chk(pos == ep, "R4/R8 fixed-stage latency slot", pos, ep);
            chk(c == mk_ctl(seq) && b == BW'(seq), "R10 payload intact", int'(c), int'(mk_ctl(seq)));
          end
          nout[k] = seq + 1;
        end
      end
    end
  endtask

  // drive one controller cycle, then observe the result after the edge
  task automatic step(bit v);
    bit exp_rdy;
    in_valid  = v;
    shift_sel = cur_ssel;
    ireg_sel  = cur_rsel;
    for (int s = 0; s < 2; s++) begin
      in_addr[s*AW +: AW] = AW'(n_in + s);
      in_bank[s*BW +: BW] = BW'(n_in + s);
      in_ctl[s*4 +: 4]    = mk_ctl(n_in + s);
    end
    #1;
    exp_rdy = !(m_dly && !cur_ssel);
    chk(rdy[0] == exp_rdy, "R6 in_ready", int'(rdy[0]), int'(exp_rdy));
    chk(rdy[1] && rdy[2], "R4 fixed-mode in_ready", int'(rdy[1] && rdy[2]), 1);
    if (v && exp_rdy) begin
      for (int s = 0; s < 2; s++) begin
        pos_in[n_in + s] = 2*(cyc + 1) + s;
        exp0[n_in + s]   = pos_in[n_in + s] + (cur_ssel ? 1 : 0) + (m_reg ? 2 : 0);
      end
      n_in += 2;
    end
    m_dly = cur_ssel;
    @(negedge clk);
    observe();
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd7919));
    for (int k = 0; k < 3; k++) nout[k] = 0;
    rst_n = 1'b0; in_valid = 1'b0; shift_sel = 1'b0; ireg_sel = 1'b0;
    in_addr = '0; in_bank = '0; in_ctl = 8'hFF;
    repeat (3) @(negedge clk);
    #1;
    chk(rdy[0] == 1'b1, "R1 reset in_ready", int'(rdy[0]), 1);
    for (int k = 0; k < 3; k++)
      chk(octl[k] == 8'hFF && oaddr[k] == '0 && obank[k] == '0, "R1 reset NOP", int'(octl[k]), 255);
    rst_n = 1'b1;

    // R2: pass-through
    cur_ssel = 1'b0;
    repeat (6) step(1'b1);
    // R5: enable delay
    cur_ssel = 1'b1;
    step(1'b1);
    chk(octl[0][3] == 1'b1, "R5 slot0 NOP after enable", int'(octl[0][3]), 1);
    repeat (6) step(1'b1);
    // R6: disable delay, held slot drained
    cur_ssel = 1'b0;
    step(1'b1);
    chk(octl[0][7:4] == 4'hF, "R6 drain slot1 NOP", int'(octl[0][7:4]), 15);
    chk(octl[0][3] == 1'b0, "R6 held slot emitted", int'(octl[0][3]), 0);
    repeat (4) step(1'b1);

    // random traffic with run-time delay toggles
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 8 == 0) cur_ssel = ~cur_ssel;
      step($urandom % 5 != 0);
    end

    // R8: extra stage in, switched over an idle gap
    cur_rsel = 1'b1;
    repeat (4) step(1'b0);
    m_reg = 1'b1;
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 8 == 0) cur_ssel = ~cur_ssel;
      step($urandom % 5 != 0);
    end

    // R9: toggling the stage select under continuous traffic has no effect
    repeat (2) step(1'b1);
    cur_rsel = 1'b0;
    repeat (3) step(1'b1);
    cur_rsel = 1'b1;
    repeat (3) step(1'b1);

    // extra stage out again
    cur_rsel = 1'b0;
    repeat (4) step(1'b0);
    m_reg = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if ($urandom % 6 == 0) cur_ssel = ~cur_ssel;
      step($urandom % 4 != 0);
    end

    repeat (8) step(1'b0);
    for (int k = 0; k < 3; k++)
      chk(nout[k] == n_in, "R10 all commands delivered", nout[k], n_in);
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      finish_run();
    end
  end
endmodule